// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block is one performance-monitor counter. An 8-bit select register chooses one event source from a 24-bit core event bus or from two external trace output lines. Each enabled cycle, the chosen event's contribution is added to a 32-bit count register.

A contribution can be 0, 1 or 2 per cycle:
- Some events carry a qualifier bit that reports a dual occurrence.
- Two other events report two simultaneous sources.
- One select code counts plain clock cycles.

Software controls the counter through a few inputs:
- an enable level;
- a synchronous clear of the count;
- a select-register write strobe;
- a write-one-to-clear strobe for the sticky overflow flag.

Software reads the count, the active select code and the overflow flag from registered outputs. Cores, caches and TLBs drive the event bus directly, one flag per bit.

Event bus bit map:

| Bit | Event | Select code |
|-----|-------|-------------|
| 0 | instruction cache miss | 0x00 |
| 1 | instruction buffer stall | 0x01 |
| 2 | data dependency stall | 0x02 |
| 3 | instruction micro-TLB miss | 0x03 |
| 4 | data micro-TLB miss | 0x04 |
| 5 | branch executed | 0x05 |
| 6 | branch mispredicted | 0x06 |
| 7 | instruction executed | 0x07 |
| 8 | cacheable data access | 0x09 |
| 9 | dual-instruction qualifier | (qualifies 0x07) |
| 10 | any data access | 0x0A |
| 11 | data cache miss | 0x0B |
| 12 | first write-back half line | 0x0C |
| 13 | second write-back half line | 0x0C |
| 14 | software PC change | 0x0D |
| 15 | dual PC-change qualifier | (qualifies 0x0D) |
| 16 | main TLB miss | 0x0F |
| 17 | external memory request | 0x10 |
| 18 | load/store queue full stall | 0x11 |
| 19 | forced write buffer drain | 0x12 |
| 20 | call executed | 0x23 |
| 21 | return executed | 0x24 |
| 22 | return predicted | 0x25 |
| 23 | return mispredicted | 0x26 |

Top module: `evsel_perf_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0, `ovf` becomes 0 and `sel_q` becomes 0x00.
- R2: With select code 0xFF, `count` rises by exactly 1 per enabled cycle, whatever `evt_bus` and `trc_out` hold.
- R3: With code 0x07, the counter adds 2 when `evt_bus[7]` and `evt_bus[9]` are both high, and adds 1 when only bit 7 is high. Bit 9 alone adds nothing.
- R4: With code 0x0D, the counter adds 2 when `evt_bus[14]` and `evt_bus[15]` are both high, and adds 1 when only bit 14 is high. Bit 15 alone adds nothing.
- R5: Code 0x20 adds `trc_out[0]` and code 0x21 adds `trc_out[1]`. Code 0x22 adds the number of high trace lines, so it adds 2 when both lines are high.
- R6: The stall codes (0x01 on bit 1, 0x02 on bit 2, 0x11 on bit 18) add 1 in every cycle their bus bit is held high.
- R7: Code 0x0C adds one per high half-line bit (`evt_bus[12]`, `evt_bus[13]`), so a full-line write-back in one cycle adds 2.
- R8: Each remaining defined code adds 1 when its bus bit is high:
  - 0x00 on bit 0, 0x03 on bit 3, 0x04 on bit 4, 0x05 on bit 5, 0x06 on bit 6;
  - 0x09 on bit 8, 0x0A on bit 10, 0x0B on bit 11;
  - 0x0F on bit 16, 0x10 on bit 17, 0x12 on bit 19;
  - 0x23 on bit 20, 0x24 on bit 21, 0x25 on bit 22, 0x26 on bit 23.
- R9: Any select code not listed in R2 to R8 never changes `count`, even with every event and trace input high.
- R10: While `en` is low, `count` and `ovf` hold their values.
- R11: When an enabled increment carries out of the count (wrapping from all ones, including a +2 step over the boundary), `ovf` becomes 1 and stays 1. It returns to 0 only after a cycle with `ovf_clr` high and no new carry; a carry in the same cycle as `ovf_clr` wins.
- R12: A cycle with `clr` high sets `count` to 0 at the next edge, overriding any increment. It leaves `ovf` unchanged.
- R13: A cycle with `sel_wr` high loads `sel_wdata` into `sel_q` at the next edge. Events in the write cycle still use the old code, and `count` is not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable level |
| clr | input | 1 | Synchronous clear of the count |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | 8 | New select code |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| evt_bus | input | 24 | Core event flags, one per bit (map above) |
| trc_out | input | 2 | External trace output lines |
| count | output | CNT_W (32) | Registered event count |
| sel_q | output | 8 | Active select code |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench attacks the qualifier bits:
- A decoder that adds qualifiers without their base event would count with bit 9 or bit 15 alone.
- One that ignores them would undercount dual-issue cycles.

Overflow is driven on a second, 8-bit-wide instance, so wraps happen within a few hundred cycles. That instance takes:
- a +1 wrap;
- a +2 step from 255 to 1;
- a wrap in the same cycle as `ovf_clr`.

A design that drops the carry of an odd crossing, or lets the clear win, shows a wrong flag there.

Further directed cases cover:
- clear against increment;
- undefined codes with every input high;
- an increment-worthy event in the cycle of a select write, which exposes a select register that takes effect at once.

// File: rtl/evsel_pkg.sv
package evsel_pkg;

  localparam int SEL_W = 8;
  localparam int EVT_W = 24;
  localparam int TRC_W = 2;
  localparam int INC_W = 2;

  // Event bus bit positions
  localparam int EB_IC_MISS   = 0;
  localparam int EB_IBUF_STL  = 1;
  localparam int EB_DDEP_STL  = 2;
  localparam int EB_IUTLB     = 3;
  localparam int EB_DUTLB     = 4;
  localparam int EB_BR_EXEC   = 5;
  localparam int EB_BR_MISP   = 6;
  localparam int EB_INSN      = 7;
  localparam int EB_DC_ACC_C  = 8;
  localparam int EB_INSN_DUAL = 9;
  localparam int EB_DC_ACC    = 10;
  localparam int EB_DC_MISS   = 11;
  localparam int EB_WB_HALF0  = 12;
  localparam int EB_WB_HALF1  = 13;
  localparam int EB_PC_SW     = 14;
  localparam int EB_PC_DUAL   = 15;
  localparam int EB_MTLB      = 16;
  localparam int EB_EXT_REQ   = 17;
  localparam int EB_LSQ_STL   = 18;
  localparam int EB_WBUF_DRN  = 19;
  localparam int EB_CALL      = 20;
  localparam int EB_RET       = 21;
  localparam int EB_RET_PRED  = 22;
  localparam int EB_RET_MISP  = 23;

  // Select codes whose increment is not a plain single bit
  localparam logic [SEL_W-1:0] SC_INSN    = 8'h07;
  localparam logic [SEL_W-1:0] SC_WB      = 8'h0C;
  localparam logic [SEL_W-1:0] SC_PC_SW   = 8'h0D;
  localparam logic [SEL_W-1:0] SC_TRC0    = 8'h20;
  localparam logic [SEL_W-1:0] SC_TRC1    = 8'h21;
  localparam logic [SEL_W-1:0] SC_TRC_ANY = 8'h22;
  localparam logic [SEL_W-1:0] SC_CYCLES  = 8'hFF;

  // Single-bit events: returns 1 and the bus bit for codes that add one per flag
  function automatic logic single_map(input logic [SEL_W-1:0] code, output int bitpos);
    single_map = 1'b1;
    bitpos = 0;
    case (code)
      8'h00: bitpos = EB_IC_MISS;
      8'h01: bitpos = EB_IBUF_STL;
      8'h02: bitpos = EB_DDEP_STL;
      8'h03: bitpos = EB_IUTLB;
      8'h04: bitpos = EB_DUTLB;
      8'h05: bitpos = EB_BR_EXEC;
      8'h06: bitpos = EB_BR_MISP;
      8'h09: bitpos = EB_DC_ACC_C;
      8'h0A: bitpos = EB_DC_ACC;
      8'h0B: bitpos = EB_DC_MISS;
      8'h0F: bitpos = EB_MTLB;
      8'h10: bitpos = EB_EXT_REQ;
      8'h11: bitpos = EB_LSQ_STL;
      8'h12: bitpos = EB_WBUF_DRN;
      8'h23: bitpos = EB_CALL;
      8'h24: bitpos = EB_RET;
      8'h25: bitpos = EB_RET_PRED;
      8'h26: bitpos = EB_RET_MISP;
      default: single_map = 1'b0;
    endcase
  endfunction

  function automatic logic code_defined(input logic [SEL_W-1:0] code);
    int unused_pos;
    code_defined = single_map(code, unused_pos) ||
                   code == SC_INSN || code == SC_WB || code == SC_PC_SW ||
                   code == SC_TRC0 || code == SC_TRC1 || code == SC_TRC_ANY ||
                   code == SC_CYCLES;
  endfunction

endpackage

// File: rtl/evsel_decode.sv
module evsel_decode
  import evsel_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [EVT_W-1:0] evt_bus,
  input  logic [TRC_W-1:0] trc_out,
  output logic [INC_W-1:0] inc
);

  logic [INC_W-1:0] trc_cnt;
  logic [INC_W-1:0] wb_cnt;

  // Population count of the trace lines
  always_comb begin
    trc_cnt = '0;
    for (int i = 0; i < TRC_W; i++) begin
      trc_cnt = trc_cnt + INC_W'(trc_out[i]);
    end
  end

  assign wb_cnt = INC_W'(evt_bus[EB_WB_HALF0]) + INC_W'(evt_bus[EB_WB_HALF1]);

  always_comb begin
    int pos;
    logic is_single;
    is_single = single_map(sel, pos);
    inc = '0;
    if (is_single) begin
      inc = INC_W'(evt_bus[pos]);
    end else begin
      case (sel)
        SC_INSN:    inc = evt_bus[EB_INSN] ? (evt_bus[EB_INSN_DUAL] ? 2'd2 : 2'd1) : 2'd0;
        SC_PC_SW:   inc = evt_bus[EB_PC_SW] ? (evt_bus[EB_PC_DUAL] ? 2'd2 : 2'd1) : 2'd0;
        SC_WB:      inc = wb_cnt;
        SC_TRC0:    inc = INC_W'(trc_out[0]);
        SC_TRC1:    inc = INC_W'(trc_out[1]);
        SC_TRC_ANY: inc = trc_cnt;
        SC_CYCLES:  inc = 2'd1;
        default:    inc = '0;
      endcase
    end
  end

endmodule

// File: rtl/evsel_sel_reg.sv
module evsel_sel_reg
  import evsel_pkg::*;
#(
  parameter logic [SEL_W-1:0] RST_SEL = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RST_SEL;
    end else if (wr) begin
      sel_q <= wdata;
    end
  end

endmodule

// File: rtl/evsel_accum.sv
module evsel_accum
  import evsel_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             ovf_clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic             carry;

  assign sum   = {1'b0, count} + SUM_W'(inc);
  assign carry = en && !clr && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (en) begin
      count <= sum[CNT_W-1:0];
    end
  end

  // A fresh carry beats a same-cycle clear so no wrap is lost
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
    end else if (carry) begin
      ovf <= 1'b1;
    end else if (ovf_clr) begin
      ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/evsel_perf_counter.sv
module evsel_perf_counter
  import evsel_pkg::*;
#(
  parameter int                CNT_W   = 32,
  parameter logic [SEL_W-1:0]  RST_SEL = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             ovf_clr,
  input  logic [EVT_W-1:0] evt_bus,
  input  logic [TRC_W-1:0] trc_out,
  output logic [CNT_W-1:0] count,
  output logic [SEL_W-1:0] sel_q,
  output logic             ovf
);

  logic [INC_W-1:0] inc;

  evsel_sel_reg #(.RST_SEL(RST_SEL)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .wr    (sel_wr),
    .wdata (sel_wdata),
    .sel_q (sel_q)
  );

  evsel_decode u_dec (
    .sel     (sel_q),
    .evt_bus (evt_bus),
    .trc_out (trc_out),
    .inc     (inc)
  );

  evsel_accum #(.CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .clr     (clr),
    .ovf_clr (ovf_clr),
    .inc     (inc),
    .count   (count),
    .ovf     (ovf)
  );

endmodule

// File: rtl/evsel_perf_counter_chk.sv
module evsel_perf_counter_chk
  import evsel_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             clr,
  input logic             sel_wr,
  input logic [SEL_W-1:0] sel_wdata,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic [SEL_W-1:0] sel_q,
  input logic             ovf
);

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && sel_q == SC_CYCLES) |=> count == CNT_W'($past(count) + 1)); // R2

  AST_STEP_MAX2: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> CNT_W'(count - $past(count)) <= CNT_W'(2)); // R5

  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !code_defined(sel_q)) |=> $stable(count)); // R9

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count)); // R10

  AST_EN_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !ovf_clr) |=> $stable(ovf)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf); // R11

  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && sel_q == SC_CYCLES && count == {CNT_W{1'b1}}) |=> ovf); // R11

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0); // R12

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> sel_q == $past(sel_wdata)); // R13

endmodule

bind evsel_perf_counter evsel_perf_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .clr       (clr),
  .sel_wr    (sel_wr),
  .sel_wdata (sel_wdata),
  .ovf_clr   (ovf_clr),
  .count     (count),
  .sel_q     (sel_q),
  .ovf       (ovf)
);

// File: tb/evsel_perf_counter_tb.sv
module evsel_perf_counter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        clr = 1'b0;
  logic        sel_wr = 1'b0;
  logic [7:0]  sel_wdata = 8'h00;
  logic        ovf_clr = 1'b0;
  logic [23:0] evt_bus = '0;
  logic [1:0]  trc_out = '0;

  logic [31:0] count;
  logic [7:0]  sel_q;
  logic        ovf;
  logic [7:0]  count8;
  logic [7:0]  sel_q8;
  logic        ovf8;

  always #5 clk = ~clk;

  evsel_perf_counter u_dut (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .ovf_clr(ovf_clr), .evt_bus(evt_bus),
    .trc_out(trc_out), .count(count), .sel_q(sel_q), .ovf(ovf)
  );

  // Narrow copy so that wraps are reachable in a short run
  evsel_perf_counter #(.CNT_W(8)) u_dut8 (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .ovf_clr(ovf_clr), .evt_bus(evt_bus),
    .trc_out(trc_out), .count(count8), .sel_q(sel_q8), .ovf(ovf8)
  );

  longint unsigned m_cnt, m_cnt8;
  bit              m_ovf, m_ovf8;
  logic [7:0]      m_sel;
  int              n_chk = 0;
  int              n_fail = 0;
  bit              done = 1'b0;

  // Expected per-cycle increment, written from R2..R9
  function automatic int exp_inc(logic [7:0] s, logic [23:0] b, logic [1:0] t);
    case (s)
      8'hFF: return 1;                                   // R2
      8'h07: return b[7] ? (b[9] ? 2 : 1) : 0;           // R3
      8'h0D: return b[14] ? (b[15] ? 2 : 1) : 0;         // R4
      8'h20: return int'(t[0]);                          // R5
      8'h21: return int'(t[1]);
      8'h22: return int'(t[0]) + int'(t[1]);
      8'h01: return int'(b[1]);                          // R6
      8'h02: return int'(b[2]);
      8'h11: return int'(b[18]);
      8'h0C: return int'(b[12]) + int'(b[13]);           // R7
      8'h00: return int'(b[0]);                          // R8
      8'h03: return int'(b[3]);
      8'h04: return int'(b[4]);
      8'h05: return int'(b[5]);
      8'h06: return int'(b[6]);
      8'h09: return int'(b[8]);
      8'h0A: return int'(b[10]);
      8'h0B: return int'(b[11]);
      8'h0F: return int'(b[16]);
      8'h10: return int'(b[17]);
      8'h12: return int'(b[19]);
      8'h23: return int'(b[20]);
      8'h24: return int'(b[21]);
      8'h25: return int'(b[22]);
      8'h26: return int'(b[23]);
      default: return 0;                                 // R9
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_cnt8 = 0; m_ovf = 0; m_ovf8 = 0; m_sel = 8'h00;
  endtask

  // Advance the model by one edge using the inputs currently driven
  task automatic model_step();
    int inc;
    longint unsigned s;
    inc = exp_inc(m_sel, evt_bus, trc_out);
    if (clr) begin
      m_cnt = 0; m_cnt8 = 0;
    end else if (en) begin
      s = m_cnt + longint'(inc);
      if (s > 64'hFFFF_FFFF) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_cnt = s & 64'hFFFF_FFFF;
      s = m_cnt8 + longint'(inc);
      if (s > 64'hFF) m_ovf8 = 1;
      else if (ovf_clr) m_ovf8 = 0;
      m_cnt8 = s & 64'hFF;
    end
    if (clr || !en) begin
      if (ovf_clr) begin m_ovf = 0; m_ovf8 = 0; end
    end
    if (sel_wr) m_sel = sel_wdata;
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " count"}, 64'(count), m_cnt);
    chk({tag, " ovf"}, 64'(ovf), 64'(m_ovf));
    chk({tag, " sel"}, 64'(sel_q), 64'(m_sel));
    chk({tag, " count8"}, 64'(count8), m_cnt8);
    chk({tag, " ovf8"}, 64'(ovf8), 64'(m_ovf8));
  endtask

  task automatic drive(logic e, logic c, logic w, logic [7:0] wd, logic oc,
                       logic [23:0] b, logic [1:0] t);
    en = e; clr = c; sel_wr = w; sel_wdata = wd; ovf_clr = oc; evt_bus = b; trc_out = t;
    cycle();
  endtask

  task automatic set_sel(logic [7:0] code);
    drive(1'b0, 1'b0, 1'b1, code, 1'b0, '0, '0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] singles [18] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h09, 8'h0A,
                                 8'h0B, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h23, 8'h24, 8'h25, 8'h26};
    logic [7:0] undef [6] = '{8'h08, 8'h0E, 8'h13, 8'h1F, 8'h27, 8'h80};
    logic [7:0] pool [26] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h09,
                              8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h20,
                              8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'hFF, 8'h0E};
    void'($urandom(32'h1F2E3D4C));

    // R1: reset state
    rst = 1'b1;
    evt_bus = '1; trc_out = '1; en = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    chk_all("R1 reset");
    rst = 1'b0;
    en = 1'b0; evt_bus = '0; trc_out = '0;

    // R13: write 0xFF while bit 0 is high under old code 0x00 -> old code counts once
    drive(1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 24'h000001, '0);
    chk_all("R13 old code in write cycle");
    chk("R13 count kept", 64'(count), 64'd1);

    // R2: cycle counting ignores inputs
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'($urandom), 2'($urandom));
    chk("R2 cycles", 64'(count), 64'd6);
    chk_all("R2 cycles");

    // R3: instruction executed with dual qualifier
    set_sel(8'h07);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h000080, '0);
    chk("R3 single", 64'(count), 64'd7);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h000280, '0);
    chk("R3 dual", 64'(count), 64'd9);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h000200, '0);
    chk("R3 qualifier alone", 64'(count), 64'd9);

    // R4: software PC change with dual qualifier
    set_sel(8'h0D);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h004000, '0);
    chk("R4 single", 64'(count), 64'd10);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h00C000, '0);
    chk("R4 dual", 64'(count), 64'd12);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h008000, '0);
    chk("R4 qualifier alone", 64'(count), 64'd12);

    // R5: trace lines
    set_sel(8'h20);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 2'b11);
    chk("R5 line0", 64'(count), 64'd13);
    set_sel(8'h21);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 2'b01);
    chk("R5 line1 idle", 64'(count), 64'd13);
    set_sel(8'h22);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 2'b11);
    chk("R5 both", 64'(count), 64'd15);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 2'b10);
    chk("R5 one", 64'(count), 64'd16);

    // R6: held stall counts every cycle
    set_sel(8'h11);
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h040000, '0);
    chk("R6 stall held", 64'(count), 64'd20);

    // R7: write-back half lines
    set_sel(8'h0C);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h003000, '0);
    chk("R7 full line", 64'(count), 64'd22);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h002000, '0);
    chk("R7 half line", 64'(count), 64'd23);

    // R8: each single-increment code with every flag high
    for (int i = 0; i < 18; i++) begin
      set_sel(singles[i]);
      drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '1, '1);
      chk_all("R8 single code");
    end
    chk("R8 total", 64'(count), 64'd41);

    // R9: undefined codes never count
    for (int i = 0; i < 6; i++) begin
      set_sel(undef[i]);
      drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '1, '1);
      chk("R9 undefined", 64'(count), 64'd41);
    end

    // R10: enable low holds
    set_sel(8'hFF);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, '1, '1);
    chk("R10 hold", 64'(count), 64'd41);

    // R12: clear beats increment
    drive(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, '1, '1);
    chk("R12 clear", 64'(count), 64'd0);
    chk_all("R12 clear");

    // R11: +1 wrap on the narrow copy
    for (int i = 0; i < 256; i++) drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, '0);
    chk("R11 wrap count8", 64'(count8), 64'd0);
    chk("R11 wrap ovf8", 64'(ovf8), 64'd1);
    drive(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, '0, '0);
    chk("R11 sticky through clr", 64'(ovf8), 64'd1);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, '0, '0);
    chk("R11 w1c", 64'(ovf8), 64'd0);

    // R11: +2 step crossing from 255 to 1
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, '0);
    set_sel(8'h07);
    for (int i = 0; i < 127; i++) drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h000280, '0);
    chk("R11 before cross", 64'(count8), 64'd255);
    chk("R11 no early ovf", 64'(ovf8), 64'd0);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h000280, '0);
    chk("R11 +2 cross count8", 64'(count8), 64'd1);
    chk("R11 +2 cross ovf8", 64'(ovf8), 64'd1);

    // R11: carry in the same cycle as ovf_clr keeps the flag
    for (int i = 0; i < 127; i++) drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 24'h000280, '0);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 24'h000280, '0);
    chk("R11 carry beats clear", 64'(ovf8), 64'd1);
    chk_all("R11 directed");

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic w;
      w = ($urandom_range(0, 9) == 0);
      drive(($urandom_range(0, 7) != 0), ($urandom_range(0, 99) == 0), w,
            pool[$urandom_range(0, 25)], ($urandom_range(0, 49) == 0),
            24'($urandom), 2'($urandom));
      chk_all("R8 random");
    end

    summary();
  end

endmodule